// File: doc/BRIEF.md
# Static and Rate-of-Change Threshold Alarm

This block watches sensor sample channels on behalf of two independent alarm units. On every sample strobe each unit takes one channel, picked by its own source field, from either the raw or the filtered sample bus, and tests it against a signed 14-bit threshold. The compare direction (above or below) comes from the top bit of the unit's threshold word. In level mode the unit compares the sample itself. In rate mode it compares the absolute change between the current sample and the sample taken a programmed number of strobes earlier. A circular history buffer in each unit holds those earlier samples.

A hit sets a sticky flag for its unit. The flag holds until a status read clears it. If the condition is still present, the next strobe sets it again. The flags can also drive one of two output lines, chosen by a 3-bit indicator field. When enabled, the driven line shows "any flag set" at the programmed polarity.

Each unit runs a small state machine with three states. `U_STATIC` is level mode. `U_FILL` is rate mode while the history is still too short. `U_TRACK` is rate mode with valid history. A change to a unit's mode, source, span or data-source selection is a *restart*: it sends the unit to `U_STATIC` (level mode) or `U_FILL` (rate mode) with an empty history count. In `U_FILL`, each strobe stores a sample; the strobe that brings the count up to the span moves the unit to `U_TRACK`. `U_STATIC` and `U_TRACK` stay where they are until the next restart.

Top module: `threshold_alarm`

## Requirements
- R1: After reset both flags are 0 and both output lines have output-enable 0 and level 0.
- R2: With threshold word bit 15 = 1, a level-mode unit flags when the selected sample, read as signed 14-bit, is strictly greater than the signed threshold in bits 13:0. An equal sample does not flag.
- R3: With bit 15 = 0, a level-mode unit flags when the sample is strictly less than the threshold. An equal sample does not flag.
- R4: In rate mode (mode bit = 1) the value compared is |current sample − sample taken N strobes earlier|, with the same direction rule as R2 and R3.
- R5: A span field of 0 and a span field of 1 both mean N = 1, the immediately preceding sample. Spans above the history depth are clamped to the depth.
- R6: After a reset or restart in rate mode, the first N strobes only fill the history and raise no alarm. Strobe N+1 is the first one compared.
- R7: Source field value c selects channel c, taken from bits [14c+13:14c] of the sample bus. A source value at or above the channel count never raises an alarm.
- R8: `use_filt` = 1 compares the filtered bus and `use_filt` = 0 compares the raw bus.
- R9: Flags are sticky. A status read clears both flags in the next cycle. A strobe that hits in the same cycle as a read leaves that unit's flag set. A later strobe with the condition still true sets the flag again.
- R10: Indicator field bit 2 enables the output, bit 1 selects the polarity (1 = high when any flag is set), and bit 0 selects the line (0 = line 0, 1 = line 1). Only the selected line has output-enable 1. With bit 2 = 0 both lines are disabled and low.
- R11: Changing a unit's mode, source, span or `use_filt` restarts that unit. In rate mode this empties its history, and the strobe in the same cycle as the change is not evaluated.
- R12: A flag never rises without a strobe, whatever the data or threshold inputs do.
- R13: Bit 14 of the threshold word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample on the buses |
| raw_bus | input | NUM_CH*14 | Unfiltered channel samples, channel c at bits [14c+13:14c] |
| filt_bus | input | NUM_CH*14 | Filtered channel samples, same packing |
| use_filt | input | 1 | 1 = compare filtered data, 0 = raw |
| alm0_word | input | 16 | Unit 0 threshold word: bit 15 direction, bits 13:0 threshold |
| alm0_span | input | 8 | Unit 0 rate-mode span N |
| alm0_dyn | input | 1 | Unit 0 mode: 1 = rate, 0 = level |
| alm0_src | input | 4 | Unit 0 source channel |
| alm1_word | input | 16 | Unit 1 threshold word |
| alm1_span | input | 8 | Unit 1 rate-mode span N |
| alm1_dyn | input | 1 | Unit 1 mode |
| alm1_src | input | 4 | Unit 1 source channel |
| ind_cfg | input | 3 | Indicator: bit 2 enable, bit 1 polarity, bit 0 line select |
| stat_rd | input | 1 | Status read pulse, clears flags |
| alm_flag | output | 2 | Sticky flags, bit u for unit u |
| pin_oe | output | 2 | Output enable for lines 0 and 1 |
| pin_out | output | 2 | Level for lines 0 and 1 |

## Verification
A corrupted history write pointer or span clamp only shows when a rate-mode unit reaches `U_TRACK`. The first compared strobe then flags or stays quiet against the wrong older sample, so the bench fills the history with widely spread values before it looks. A fill count that runs off by one moves the first possible alarm by one strobe, and the fill-phase checks see that at once. A flag register that loses its hold, or that misses the set-over-clear rule, shows one cycle after the offending strobe or read. A wrong line-select or polarity decode shows on `pin_oe` and `pin_out` in the same cycle as the flags.

// File: rtl/thr_alarm_pkg.sv
`timescale 1ns/1ps
package thr_alarm_pkg;
    localparam int SMP_W  = 14;
    localparam int WORD_W = 16;
    localparam int SPAN_W = 8;
    localparam int SRC_W  = 4;

    typedef enum logic [1:0] {
        U_STATIC = 2'd0,
        U_FILL   = 2'd1,
        U_TRACK  = 2'd2
    } unit_state_e;

    typedef struct packed {
        logic              dyn;
        logic [SRC_W-1:0]  src;
        logic [SPAN_W-1:0] span;
        logic              filt;
    } unit_cfg_t;
endpackage

// File: rtl/alarm_hist.sv
`timescale 1ns/1ps
module alarm_hist
    import thr_alarm_pkg::*;
#(
    parameter int DEPTH = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SMP_W-1:0]  wr_data,
    input  logic [SPAN_W-1:0] back,
    output logic [SMP_W-1:0]  rd_data
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0]   DEP_X = (PW+1)'(DEPTH);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);

    logic [SMP_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wp;
    logic [PW:0]      rsum;
    logic [PW-1:0]    rd_idx;

    // write pointer walks the ring; back <= DEPTH is guaranteed by the unit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wp <= '0;
        else if (wr_en)
            wp <= (wp == LAST) ? '0 : wp + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wp] <= wr_data;
    end

    // entry written 'back' strobes ago, read before this strobe overwrites it
    always_comb begin
        rsum = {1'b0, wp} + DEP_X - (PW+1)'(back);
        if (rsum >= DEP_X)
            rsum = rsum - DEP_X;
        rd_idx  = rsum[PW-1:0];
        rd_data = mem[rd_idx];
    end
endmodule

// File: rtl/alarm_unit.sv
`timescale 1ns/1ps
module alarm_unit
    import thr_alarm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DEPTH  = 255
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic [NUM_CH*SMP_W-1:0] raw_bus,
    input  logic [NUM_CH*SMP_W-1:0] filt_bus,
    input  logic                    use_filt,
    input  logic [WORD_W-1:0]       word,
    input  logic [SPAN_W-1:0]       span,
    input  logic                    dyn,
    input  logic [SRC_W-1:0]        src,
    output logic                    hit
);
    localparam int                DX      = SMP_W + 2;
    localparam logic [SPAN_W-1:0] DEPTH_S = SPAN_W'(DEPTH);

    unit_state_e state_q, state_d;
    logic [SPAN_W-1:0] cnt_q, cnt_d;
    unit_cfg_t cfg_now, cfg_q;
    logic restart;

    logic [NUM_CH*SMP_W-1:0] bus;
    logic [SMP_W-1:0]  cur;
    logic              src_ok;
    logic [SPAN_W-1:0] span_eff;
    logic [SMP_W-1:0]  old;
    logic              wr_en;
    logic signed [DX-1:0] cur_x, old_x, diff, mag, val, thr_x;
    logic cmp, valid;
    logic spare_unused;

    assign spare_unused = word[14];

    // ---- channel selection ----
    assign bus = use_filt ? filt_bus : raw_bus;

    always_comb begin
        cur    = '0;
        src_ok = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (src == SRC_W'(c)) begin
                cur    = bus[c*SMP_W +: SMP_W];
                src_ok = 1'b1;
            end
        end
    end

    // ---- span: 0 and 1 both mean one step back, clamp to buffer depth ----
    always_comb begin
        if (span <= SPAN_W'(1))
            span_eff = SPAN_W'(1);
        else if (span > DEPTH_S)
            span_eff = DEPTH_S;
        else
            span_eff = span;
    end

    // ---- restart detection ----
    assign cfg_now = '{dyn: dyn, src: src, span: span, filt: use_filt};
    assign restart = (cfg_now != cfg_q);

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= U_STATIC;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cfg_q   <= cfg_now;
        end
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = dyn ? U_FILL : U_STATIC;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                U_STATIC: begin
                    state_d = U_STATIC;
                end
                U_FILL: begin
                    if (smp_stb) begin
                        cnt_d = cnt_q + SPAN_W'(1);
                        if (cnt_q + SPAN_W'(1) == span_eff)
                            state_d = U_TRACK;
                    end
                end
                U_TRACK: begin
                    state_d = U_TRACK;
                end
                default: begin
                    state_d = U_STATIC;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // ---- history ----
    assign wr_en = smp_stb && !restart && (state_q != U_STATIC);

    alarm_hist #(.DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (cur),
        .back    (span_eff),
        .rd_data (old)
    );

    // ---- outputs: compare and hit ----
    always_comb begin
        cur_x = DX'(signed'(cur));
        old_x = DX'(signed'(old));
        thr_x = DX'(signed'(word[SMP_W-1:0]));
        diff  = cur_x - old_x;
        mag   = diff[DX-1] ? -diff : diff;
        valid = 1'b0;
        val   = cur_x;
        unique case (state_q)
            U_STATIC: begin valid = 1'b1; val = cur_x; end
            U_FILL:   begin valid = 1'b0; val = mag;   end
            U_TRACK:  begin valid = 1'b1; val = mag;   end
            default:  begin valid = 1'b0; val = cur_x; end
        endcase
        cmp = word[WORD_W-1] ? (val > thr_x) : (val < thr_x);
        hit = smp_stb && !restart && src_ok && valid && cmp;
    end
endmodule

// File: rtl/alarm_out.sv
`timescale 1ns/1ps
module alarm_out #(
    parameter int NUM_ALM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ALM-1:0] hit,
    input  logic               stat_rd,
    input  logic [2:0]         ind_cfg,
    output logic [NUM_ALM-1:0] alm_flag,
    output logic [1:0]         pin_oe,
    output logic [1:0]         pin_out
);
    logic [NUM_ALM-1:0] flag_q;
    logic any, lvl, en, sel;

    // sticky flags: a fresh hit wins over a clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= hit | (stat_rd ? '0 : flag_q);
    end

    assign alm_flag = flag_q;
    assign en  = ind_cfg[2];
    assign sel = ind_cfg[0];
    assign any = |flag_q;
    assign lvl = ind_cfg[1] ? any : ~any;

    always_comb begin
        pin_oe  = 2'b00;
        pin_out = 2'b00;
        if (en) begin
            pin_oe[sel]  = 1'b1;
            pin_out[sel] = lvl;
        end
    end
endmodule

// File: rtl/threshold_alarm.sv
`timescale 1ns/1ps
module threshold_alarm
    import thr_alarm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DEPTH  = 255
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic [NUM_CH*SMP_W-1:0] raw_bus,
    input  logic [NUM_CH*SMP_W-1:0] filt_bus,
    input  logic                    use_filt,
    input  logic [WORD_W-1:0]       alm0_word,
    input  logic [SPAN_W-1:0]       alm0_span,
    input  logic                    alm0_dyn,
    input  logic [SRC_W-1:0]        alm0_src,
    input  logic [WORD_W-1:0]       alm1_word,
    input  logic [SPAN_W-1:0]       alm1_span,
    input  logic                    alm1_dyn,
    input  logic [SRC_W-1:0]        alm1_src,
    input  logic [2:0]              ind_cfg,
    input  logic                    stat_rd,
    output logic [1:0]              alm_flag,
    output logic [1:0]              pin_oe,
    output logic [1:0]              pin_out
);
    localparam int NUM_ALM = 2;

    logic [WORD_W-1:0] word_a [NUM_ALM];
    logic [SPAN_W-1:0] span_a [NUM_ALM];
    logic [SRC_W-1:0]  src_a  [NUM_ALM];
    logic [NUM_ALM-1:0] dyn_a;
    logic [NUM_ALM-1:0] hit;

    assign word_a[0] = alm0_word;
    assign word_a[1] = alm1_word;
    assign span_a[0] = alm0_span;
    assign span_a[1] = alm1_span;
    assign src_a[0]  = alm0_src;
    assign src_a[1]  = alm1_src;
    assign dyn_a     = {alm1_dyn, alm0_dyn};

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_unit
        alarm_unit #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_stb  (smp_stb),
            .raw_bus  (raw_bus),
            .filt_bus (filt_bus),
            .use_filt (use_filt),
            .word     (word_a[g]),
            .span     (span_a[g]),
            .dyn      (dyn_a[g]),
            .src      (src_a[g]),
            .hit      (hit[g])
        );
    end

    alarm_out #(.NUM_ALM(NUM_ALM)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .stat_rd  (stat_rd),
        .ind_cfg  (ind_cfg),
        .alm_flag (alm_flag),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out)
    );
endmodule

// File: rtl/thr_alarm_chk.sv
`timescale 1ns/1ps
module thr_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_stb,
    input logic       stat_rd,
    input logic [2:0] ind_cfg,
    input logic [1:0] alm_flag,
    input logic [1:0] pin_oe,
    input logic [1:0] pin_out
);
    assert_rise0_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag[0]) |-> $past(smp_stb));

    assert_rise1_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag[1]) |-> $past(smp_stb));

    assert_fall_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(alm_flag[0]) || $fell(alm_flag[1])) |-> $past(stat_rd));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(smp_stb) && !$past(stat_rd)) |-> $stable(alm_flag));

    assert_pin_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_oe));

    assert_pin_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_cfg[2] && !ind_cfg[1] && alm_flag == 2'b00) |-> (pin_out != 2'b00));
endmodule

bind threshold_alarm thr_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .stat_rd  (stat_rd),
    .ind_cfg  (ind_cfg),
    .alm_flag (alm_flag),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out)
);

// File: tb/threshold_alarm_tb.sv
`timescale 1ns/1ps
module threshold_alarm_tb;
    localparam int NCH = 6;
    localparam int SW  = 14;
    localparam logic [15:0] QUIET0 = {1'b1, 1'b0, 14'h1FFF};
    localparam logic [15:0] QUIET1 = {1'b0, 1'b0, 14'h2000};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, smp_stb, use_filt, stat_rd;
    logic [NCH*SW-1:0] raw_bus, filt_bus;
    logic signed [SW-1:0] raw_ch [NCH];
    logic signed [SW-1:0] filt_ch [NCH];
    logic [15:0] w0, w1;
    logic [7:0]  n0, n1;
    logic        d0, d1;
    logic [3:0]  s0, s1;
    logic [2:0]  ind;
    logic [1:0]  alm_flag, pin_oe, pin_out;
    int n_chk = 0;
    int n_bad = 0;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            raw_bus[c*SW +: SW]  = raw_ch[c];
            filt_bus[c*SW +: SW] = filt_ch[c];
        end
    end

    threshold_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .raw_bus(raw_bus), .filt_bus(filt_bus), .use_filt(use_filt),
        .alm0_word(w0), .alm0_span(n0), .alm0_dyn(d0), .alm0_src(s0),
        .alm1_word(w1), .alm1_span(n1), .alm1_dyn(d1), .alm1_src(s1),
        .ind_cfg(ind), .stat_rd(stat_rd),
        .alm_flag(alm_flag), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [15:0] mk(input logic gt, input int thr);
        logic [13:0] t;
        t = 14'(thr);
        return {gt, 1'b0, t};
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe();
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
    endtask

    task automatic strobe0(input int v);
        raw_ch[0] = SW'(v);
        strobe();
    endtask

    task automatic clear_flags();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", {2'b00, alm_flag}, 4'b0000);
        chk("R1 pins after reset", {pin_oe, pin_out}, 4'b0000);
    endtask

    task automatic t_static_gt();
        w0 = mk(1'b1, 100); tick();
        strobe0(100);
        chk("R2 equal no alarm", {2'b00, alm_flag}, 4'b0000);
        strobe0(101);
        chk("R2 greater alarm", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        w0 = mk(1'b1, -50); tick();
        strobe0(-40);
        chk("R2 signed greater", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        strobe0(-60);
        chk("R2 signed below", {2'b00, alm_flag}, 4'b0000);
        w0 = QUIET0; raw_ch[0] = '0; tick();
    endtask

    task automatic t_static_lt();
        w1 = mk(1'b0, -20); raw_ch[5] = -14'sd21; tick();
        strobe();
        chk("R3 less alarm", {2'b00, alm_flag}, 4'b0010);
        clear_flags();
        raw_ch[5] = -14'sd20;
        strobe();
        chk("R3 equal no alarm", {2'b00, alm_flag}, 4'b0000);
        w1 = mk(1'b0, -20) | 16'h4000; raw_ch[5] = -14'sd21; tick();
        strobe();
        chk("R13 bit14 ignored", {2'b00, alm_flag}, 4'b0010);
        clear_flags();
        w1 = QUIET1; raw_ch[5] = '0; tick();
    endtask

    task automatic t_sticky();
        w0 = mk(1'b1, 10); tick();
        raw_ch[0] = 14'sd20; tick(); tick();
        chk("R12 no strobe no alarm", {2'b00, alm_flag}, 4'b0000);
        strobe();
        chk("R9 set", {2'b00, alm_flag}, 4'b0001);
        strobe0(0);
        chk("R9 sticky hold", {2'b00, alm_flag}, 4'b0001);
        raw_ch[0] = 14'sd20;
        stat_rd = 1'b1; smp_stb = 1'b1; tick(); stat_rd = 1'b0; smp_stb = 1'b0;
        chk("R9 set wins over read", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        chk("R9 cleared by read", {2'b00, alm_flag}, 4'b0000);
        strobe();
        chk("R9 reassert", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        w0 = QUIET0; raw_ch[0] = '0; tick();
    endtask

    task automatic t_source();
        w0 = mk(1'b1, 1000); s0 = 4'd3; use_filt = 1'b0;
        raw_ch[3] = 14'sd5; filt_ch[3] = 14'sd2000; tick();
        strobe();
        chk("R8 raw path", {2'b00, alm_flag}, 4'b0000);
        use_filt = 1'b1; tick();
        strobe();
        chk("R8 filtered path", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        for (int c = 0; c < NCH; c++) filt_ch[c] = 14'sd2000;
        s0 = 4'd9; tick();
        strobe();
        chk("R7 out of range source", {2'b00, alm_flag}, 4'b0000);
        for (int c = 0; c < NCH; c++) filt_ch[c] = '0;
        filt_ch[3] = 14'sd2000;
        s0 = 4'd2; tick();
        strobe();
        chk("R7 other channel quiet", {2'b00, alm_flag}, 4'b0000);
        s0 = 4'd3; tick();
        strobe();
        chk("R7 selected channel", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        use_filt = 1'b0; s0 = 4'd0; w0 = QUIET0; filt_ch[3] = '0; raw_ch[3] = '0; tick();
    endtask

    task automatic t_dynamic();
        d0 = 1'b1; n0 = 8'd3; w0 = mk(1'b1, 50); tick();
        strobe0(0);
        strobe0(500);
        strobe0(-500);
        chk("R6 no alarm while filling", {2'b00, alm_flag}, 4'b0000);
        strobe0(40);
        chk("R4 change 40 below", {2'b00, alm_flag}, 4'b0000);
        strobe0(560);
        chk("R4 change 60 above", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        strobe0(-551);
        chk("R4 negative change abs", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        strobe0(90);
        chk("R4 change equal no alarm", {2'b00, alm_flag}, 4'b0000);
    endtask

    task automatic t_span();
        n0 = 8'd0; w0 = mk(1'b1, 5); tick();
        strobe0(100);
        chk("R6 span0 first strobe fills", {2'b00, alm_flag}, 4'b0000);
        strobe0(106);
        chk("R5 span0 one step", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        n0 = 8'd1; tick();
        strobe0(0);
        chk("R5 span1 first strobe fills", {2'b00, alm_flag}, 4'b0000);
        strobe0(10);
        chk("R5 span1 one step", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
    endtask

    task automatic t_restart();
        strobe0(12);
        chk("R11 small change quiet", {2'b00, alm_flag}, 4'b0000);
        raw_ch[1] = 14'sd1000; s0 = 4'd1; tick();
        strobe();
        chk("R11 restart refills", {2'b00, alm_flag}, 4'b0000);
        strobe();
        chk("R11 no change quiet", {2'b00, alm_flag}, 4'b0000);
        raw_ch[1] = 14'sd1100;
        strobe();
        chk("R11 compares after refill", {2'b00, alm_flag}, 4'b0001);
        clear_flags();
        d0 = 1'b0; s0 = 4'd0; n0 = 8'd0; w0 = QUIET0; raw_ch[1] = '0; raw_ch[0] = '0; tick();
    endtask

    task automatic t_pin();
        ind = 3'b100; tick();
        chk("R10 active-low idle line0", {pin_oe, pin_out}, 4'b0101);
        w0 = mk(1'b1, 10); tick();
        strobe0(20);
        chk("R10 active-low asserted", {pin_oe, pin_out}, 4'b0100);
        ind = 3'b111; tick();
        chk("R10 line1 active-high", {pin_oe, pin_out}, 4'b1010);
        ind = 3'b110; tick();
        chk("R10 line0 active-high", {pin_oe, pin_out}, 4'b0101);
        clear_flags();
        chk("R10 active-high idle", {pin_oe, pin_out}, 4'b0100);
        ind = 3'b000; tick();
        chk("R10 disabled", {pin_oe, pin_out}, 4'b0000);
        w0 = QUIET0; raw_ch[0] = '0; tick();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; smp_stb = 1'b0; stat_rd = 1'b0; use_filt = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            raw_ch[c] = '0;
            filt_ch[c] = '0;
        end
        w0 = QUIET0; w1 = QUIET1; n0 = 8'd0; n1 = 8'd0;
        d0 = 1'b0; d1 = 1'b0; s0 = 4'd0; s1 = 4'd5; ind = 3'b000;
        repeat (4) tick();
        rst_n = 1'b1;
        tick(); tick();
        t_reset();
        t_static_gt();
        t_static_lt();
        t_sticky();
        t_source();
        t_dynamic();
        t_span();
        t_restart();
        t_pin();
        finish_run();
    end
endmodule